// File: doc/BRIEF.md
# Scanned Key-Matrix Encoder

This block finds a pressed key in an 8 x 8 switch matrix and turns its position into a 6-bit key code. It drives one row line low at a time, with a ring pattern that holds a single zero among ones. It then reads the eight active-low column lines through a two-stage synchroniser. A key in the driven row pulls its column low. When any synchronised column is low at an accepted scan tick, the ring stops. The block then waits a fixed number of clock cycles. Partway through that wait, it loads the row and column indices into the key-code register and pulses a one-cycle strobe. After the wait, the ring moves on to the next row and scanning continues.

The scan rate comes from the `scan_tick` enable, which is nominally a few kilohertz derived from the system clock. A tick only has an effect in the SCAN state. A key that stays held is reported again each time the ring comes back to its row. Any repeat filtering belongs to the consumer.

The controller has five states. ST_SETTLE waits SYNC_STAGES cycles after each row change so that the synchronised columns reflect the new row. ST_SCAN waits for a tick. ST_FREEZE holds the ring until the load cycle. ST_LATCH is the single load cycle. ST_RELEASE holds the ring for the rest of the hold interval.

The transitions are:
- reset -> ST_SETTLE
- ST_SETTLE -> ST_SCAN when the settle count ends
- ST_SCAN -> ST_FREEZE on a tick with a key seen
- ST_SCAN -> ST_SETTLE on a tick with no key seen, stepping the ring
- ST_FREEZE -> ST_LATCH when the hold count reaches LOAD_AT
- ST_LATCH -> ST_RELEASE always
- ST_RELEASE -> ST_SETTLE when the hold count reaches HOLD_CYCLES-1, stepping the ring

Top module: `keymat_scanner`

## Requirements
- R1: After reset, `row_n` is 8'hFE (row 0 driven low), `key_code` is 0 and `code_valid` is 0, and the row stays put until a scan tick is accepted.
- R2: Exactly one bit of `row_n` is low at all times. Each accepted tick that sees no key moves the zero from row i to row i+1 (a rotate toward the MSB), and row 7 wraps to row 0.
- R3: Columns pass through a two-flop synchroniser. After every row change, ticks are ignored for SYNC_STAGES (2) cycles. With `scan_tick` held high and no key pressed, the row therefore changes every 3 cycles.
- R4: A key is seen when any synchronised column is 0. An accepted tick that sees a key freezes `row_n` for HOLD_CYCLES (8) cycles, after which the ring advances by one row.
- R5: The load happens in hold cycle LOAD_AT (3), counting the first hold cycle as 0. At that edge, `key_code` takes {row index in bits [5:3], column index in bits [2:0]}, where each index is the binary number 0 to 7 of the low line. `code_valid` is high for exactly the one following cycle, while the row is still frozen.
- R6: When several columns are low, the lowest-numbered column is encoded.
- R7: If no synchronised column is low in the load cycle, no strobe is produced and `key_code` keeps its previous value. `key_code` never changes except together with a strobe.
- R8: Scan ticks that arrive during the hold interval have no effect on the row or on the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_tick | input | 1 | Scan step enable, one clock wide per step |
| col_n | input | 8 | Column sense lines, active low, asynchronous |
| row_n | output | 8 | Row drives, active low, one low at a time |
| key_code | output | 6 | Stored code {row[2:0], column[2:0]} |
| code_valid | output | 1 | One-cycle strobe when key_code is loaded |

## Verification
The bench drives `scan_tick` both sparsely and held high. Held-high ticks expose a controller that samples columns before the synchroniser has caught up with the new row: it would report a key in the wrong row, or skip the settle wait and step every cycle. The bench presses two columns in one row to catch an encoder that favours the highest index. It also releases a key inside the hold window, before the load cycle. A design that loads blindly would then strobe a code with a garbage column, or would change `key_code` without a strobe. Finally, the bench measures how long the ring stays frozen after the strobe. A wrong hold count, or a hold that ticks through, shows up as an early or late row change.

// File: rtl/keymat_pkg.sv
package keymat_pkg;

    typedef enum logic [2:0] {
        ST_SETTLE  = 3'd0,
        ST_SCAN    = 3'd1,
        ST_FREEZE  = 3'd2,
        ST_LATCH   = 3'd3,
        ST_RELEASE = 3'd4
    } scan_state_e;

endpackage

// File: rtl/keymat_sync.sv
module keymat_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '1;
                    else        stg[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '1;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/keymat_ring.sv
module keymat_ring #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [N-1:0] ring_n
);
    localparam logic [N-1:0] START = {{(N-1){1'b1}}, 1'b0};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ring_n <= START;
        else if (step) ring_n <= {ring_n[N-2:0], ring_n[N-1]};
    end
endmodule

// File: rtl/keymat_prienc.sv
module keymat_prienc #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  lines_n,
    output logic [IW-1:0] idx,
    output logic          found
);
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!lines_n[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/keymat_scanner.sv
module keymat_scanner #(
    parameter int ROWS        = 8,
    parameter int COLS        = 8,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 8,
    parameter int LOAD_AT     = 3,
    localparam int RW         = $clog2(ROWS),
    localparam int CW         = $clog2(COLS),
    localparam int KW         = RW + CW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scan_tick,
    input  logic [COLS-1:0] col_n,
    output logic [ROWS-1:0] row_n,
    output logic [KW-1:0]   key_code,
    output logic            code_valid
);
    import keymat_pkg::*;

    localparam int SETTLE_CYC = SYNC_STAGES;
    localparam int CNT_MAX    = (HOLD_CYCLES > SETTLE_CYC) ? HOLD_CYCLES : SETTLE_CYC;
    localparam int CNTW       = $clog2(CNT_MAX + 1);

    scan_state_e     state, state_nxt;
    logic [CNTW-1:0] cnt, cnt_nxt;
    logic [COLS-1:0] col_sync;
    logic [RW-1:0]   row_idx;
    logic [CW-1:0]   col_idx;
    logic            row_found;
    logic            key_hit;
    logic            ring_step;

    keymat_sync #(.WIDTH(COLS), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (col_n),
        .dout  (col_sync)
    );

    keymat_ring #(.N(ROWS)) i_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (ring_step),
        .ring_n (row_n)
    );

    keymat_prienc #(.N(ROWS), .IW(RW)) i_row_enc (
        .lines_n (row_n),
        .idx     (row_idx),
        .found   (row_found)
    );

    keymat_prienc #(.N(COLS), .IW(CW)) i_col_enc (
        .lines_n (col_sync),
        .idx     (col_idx),
        .found   (key_hit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SETTLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        ring_step = 1'b0;
        unique case (state)
            ST_SETTLE: begin
                if (cnt == CNTW'(SETTLE_CYC - 1)) state_nxt = ST_SCAN;
            end
            ST_SCAN: begin
                if (scan_tick) begin
                    if (key_hit) begin
                        state_nxt = ST_FREEZE;
                    end else begin
                        state_nxt = ST_SETTLE;
                        ring_step = 1'b1;
                    end
                end
            end
            ST_FREEZE: begin
                if (cnt == CNTW'(LOAD_AT - 1)) state_nxt = ST_LATCH;
            end
            ST_LATCH: begin
                state_nxt = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (cnt == CNTW'(HOLD_CYCLES - 1)) begin
                    state_nxt = ST_SETTLE;
                    ring_step = 1'b1;
                end
            end
            default: state_nxt = ST_SETTLE;
        endcase
    end

    // interval counter: restarts on entry to a timed state
    always_comb begin
        if (state_nxt != state &&
            (state_nxt == ST_SETTLE || state_nxt == ST_FREEZE || state_nxt == ST_SCAN))
            cnt_nxt = '0;
        else if (state == ST_SCAN)
            cnt_nxt = '0;
        else
            cnt_nxt = cnt + CNTW'(1);
    end

    // outputs: code register and strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_code   <= '0;
            code_valid <= 1'b0;
        end else begin
            code_valid <= 1'b0;
            if (state == ST_LATCH && key_hit && row_found) begin
                key_code   <= {row_idx, col_idx};
                code_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/keymat_scanner_chk.sv
module keymat_scanner_chk #(
    parameter int ROWS = 8,
    parameter int KW   = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic [ROWS-1:0] row_n,
    input logic [KW-1:0]   key_code,
    input logic            code_valid
);
    localparam int RW = $clog2(ROWS);

    function automatic logic [ROWS-1:0] rot_up(input logic [ROWS-1:0] v);
        return {v[ROWS-2:0], v[ROWS-1]};
    endfunction

    function automatic logic [RW-1:0] low_index(input logic [ROWS-1:0] v);
        logic [RW-1:0] r;
        r = '0;
        for (int i = 0; i < ROWS; i++) if (!v[i]) r = RW'(i);
        return r;
    endfunction

    AST_ONE_ROW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(~row_n)); // R2

    AST_RING_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(row_n) |-> row_n == rot_up($past(row_n))); // R2

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |=> !code_valid); // R5

    AST_CODE_ROW_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> key_code[KW-1:KW-RW] == low_index(row_n)); // R5

    AST_CODE_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(key_code) |-> code_valid); // R7

    AST_FROZEN_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |=> $stable(row_n)); // R4
endmodule

bind keymat_scanner keymat_scanner_chk #(.ROWS(ROWS), .KW(KW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .row_n      (row_n),
    .key_code   (key_code),
    .code_valid (code_valid)
);

// File: tb/test_keymat_scanner.sv
module test_keymat_scanner;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 8;
    localparam int LOAD_AT    = 3;
    localparam int SETTLE     = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scan_tick = 1'b0;
    logic [7:0] col_n;
    logic [7:0] row_n;
    logic [5:0] key_code;
    logic       code_valid;
    logic [7:0] pressed [8];

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keymat_scanner i_keymat_scanner (
        .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .col_n(col_n),
        .row_n(row_n), .key_code(key_code), .code_valid(code_valid)
    );

    // switch matrix: a driven-low row pulls down every pressed column
    always @* begin
        col_n = 8'hFF;
        for (int r = 0; r < 8; r++) if (!row_n[r]) col_n = col_n & ~pressed[r];
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_row, m_state, m_cnt, m_code, m_valid;  // state: 0 settle, 1 scan, 2 hold
    int syncq[$];

    function automatic int lowest_col(input int v);
        for (int c = 0; c < 8; c++) if (((v >> c) & 1) == 0) return c;
        return -1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_row = 0; m_state = 0; m_cnt = 0; m_code = 0; m_valid = 0;
            syncq = '{255, 255};
        end else begin
            int seen;
            int colnow;
            seen   = syncq[1];
            colnow = ~pressed[m_row] & 8'hFF;
            syncq  = '{colnow, syncq[0]};
            m_valid = 0;
            case (m_state)
                0: if (m_cnt == SETTLE - 1) begin m_state = 1; m_cnt = 0; end
                   else m_cnt++;
                1: if (scan_tick) begin
                       if (lowest_col(seen) >= 0) begin m_state = 2; m_cnt = 0; end
                       else begin m_row = (m_row + 1) % 8; m_state = 0; m_cnt = 0; end
                   end
                default: begin
                    if (m_cnt == LOAD_AT && lowest_col(seen) >= 0) begin
                        m_code = m_row * 8 + lowest_col(seen);
                        m_valid = 1;
                    end
                    if (m_cnt == HOLD - 1) begin
                        m_row = (m_row + 1) % 8; m_state = 0; m_cnt = 0;
                    end else m_cnt++;
                end
            endcase
        end
    end

    // compare on every clock, away from the active edge
    int strobes = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 R3 R4 R8 row", row_n, (~(1 << m_row)) & 8'hFF);
            check("R5 R6 R7 code", key_code, m_code);
            check("R5 strobe", code_valid, m_valid);
            if (code_valid) strobes++;
        end
    end

    task automatic run(input int cycles, input int period);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            scan_tick = (period == 0) ? 1'b0 : ((i % period) == 0);
        end
    endtask

    task automatic wait_strobe(output bit got);
        got = 1'b0;
        scan_tick = 1'b1;
        for (int i = 0; i < 400 && !got; i++) begin
            @(negedge clk);
            if (code_valid) got = 1'b1;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        bit got;
        int held;
        logic [7:0] r0;
        for (int r = 0; r < 8; r++) pressed[r] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 row_n", row_n, 8'hFE);
        check("R1 key_code", key_code, 0);
        check("R1 code_valid", code_valid, 0);
        rst_n = 1'b1;
        run(10, 0);
        check("R1 no tick no step", row_n, 8'hFE);

        // R2: eight accepted ticks sweep all rows and wrap
        run(32, 4);
        check("R2 ring wrapped", row_n, 8'hFE);

        // R3: held tick, no key: row period is settle + 1
        scan_tick = 1'b1;
        r0 = row_n;
        for (int i = 0; i < 10 && row_n == r0; i++) @(negedge clk);
        r0 = row_n; held = 0;
        for (int i = 0; i < 10 && row_n == r0; i++) begin @(negedge clk); held++; end
        check("R3 step spacing", held, SETTLE + 1);

        // R5 R4 R8: key row 5 column 2, ticks held high through the hold
        pressed[5] = 8'h04;
        wait_strobe(got);
        check("R5 strobe seen", got, 1);
        check("R5 code", key_code, 6'o52);
        r0 = row_n; held = 0;
        for (int i = 0; i < 20 && row_n == r0; i++) begin held++; @(negedge clk); end
        check("R4 R8 frozen after strobe", held, HOLD - LOAD_AT - 1);
        pressed[5] = 8'h00;
        run(30, 1);

        // R6: two columns in row 3, lowest wins
        pressed[3] = 8'h42;
        wait_strobe(got);
        check("R6 strobe seen", got, 1);
        check("R6 lowest column", key_code, 3 * 8 + 1);
        pressed[3] = 8'h00;
        run(30, 1);

        // R7: key released inside the hold before the load cycle
        pressed[4] = 8'h01;
        scan_tick = 1'b1;
        for (int i = 0; i < 400 && m_state != 2; i++) @(negedge clk);
        pressed[4] = 8'h00;
        held = strobes;
        run(20, 1);
        check("R7 no strobe", strobes - held, 0);
        check("R7 code kept", key_code, 3 * 8 + 1);

        run(10, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule